// File: doc/BRIEF.md
# Word ALU with Status Flags

This block is the execution unit of a small accumulator machine. A 16-bit register operand and a 16-bit memory operand go in, together with an operation code. The result comes out combinationally in the same cycle. The supported operations are loads (word and byte), add, subtract, AND, OR, invert, two's-complement negate, and a pass-through used when a register is written to memory.

Four status flags sit in a registered flag bank. They are negative, zero, signed overflow and carry. When the flag-write enable is high, each operation updates only the flags it owns on the next rising clock edge. Logic and load operations update negative and zero and leave overflow and carry alone. Add and subtract update all four. The pass-through updates none.

The register file, instruction decode and memory access belong to the surrounding datapath. That datapath writes `result` back and holds `flag_we` high on the cycle an instruction executes.

Top module: `word_alu_nzvc`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears all four flags to 0, and it wins over a simultaneous flag write.
- R2: Add (`op_sel`=3) outputs `reg_opnd + mem_opnd` modulo 2^16. With a flag write it sets C to the carry out of bit 15, and V when both operands share a sign that the result does not have.
- R3: Subtract (`op_sel`=4) outputs `reg_opnd + ~mem_opnd + 1` modulo 2^16. C is the carry out of that sum, so C=1 means no borrow. V is set when the operands differ in sign and the result sign differs from the `reg_opnd` sign.
- R4: AND (`op_sel`=5) and OR (`op_sel`=6) output the bitwise combination of the two operands. They update N and Z only; V and C keep their previous values.
- R5: Invert (`op_sel`=7) outputs `~reg_opnd` and negate (`op_sel`=8) outputs `-reg_opnd`. Both update N and Z only.
- R6: Load word (`op_sel`=1) outputs `mem_opnd` and updates N and Z only.
- R7: Load byte (`op_sel`=2) outputs `{reg_opnd[15:8], mem_opnd[7:0]}`; `mem_opnd[15:8]` is ignored. N and Z are taken from the full 16-bit result, and only N and Z are updated.
- R8: Pass-through (`op_sel`=0) and every unused code (9 to 15) output `reg_opnd` and leave all flags unchanged, even with `flag_we` high.
- R9: With `flag_we` low, no flag changes at a clock edge, whatever the operation.
- R10: For flag-affecting operations, N is bit 15 of the result and Z is 1 exactly when the result is 0. Flags change only at the rising edge that samples the write, so they are visible from the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; flags update on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| reg_opnd | input | 16 | Register operand |
| mem_opnd | input | 16 | Memory operand (low byte only for load byte) |
| op_sel | input | 4 | Operation code (0 pass, 1 load word, 2 load byte, 3 add, 4 subtract, 5 AND, 6 OR, 7 invert, 8 negate) |
| flag_we | input | 1 | Flag-write enable for the current operation |
| result | output | 16 | Combinational result |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Signed-overflow flag |
| flag_c | output | 1 | Carry flag |

## Verification
The properties assume that `op_sel`, the operands and `flag_we` are stable from just after one rising edge until the next. This is because the flag checks compare post-edge flags against operand values sampled at that edge. The stimulus changes every input only on the falling edge, and resets only with whole-cycle pulses. Unused operation codes are driven deliberately, so the assertions make no assumption that `op_sel` stays within the defined set.

// File: rtl/word_alu_pkg.sv
package word_alu_pkg;

    localparam int unsigned WORD_W = 16;
    localparam int unsigned BYTE_W = 8;
    localparam int unsigned OP_W   = 4;

    typedef enum logic [OP_W-1:0] {
        OP_PASS = 4'd0,
        OP_LDW  = 4'd1,
        OP_LDB  = 4'd2,
        OP_ADD  = 4'd3,
        OP_SUB  = 4'd4,
        OP_AND  = 4'd5,
        OP_OR   = 4'd6,
        OP_INV  = 4'd7,
        OP_NEG  = 4'd8
    } alu_op_e;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } nzvc_t;

    typedef struct packed {
        logic upd_nz;
        logic upd_vc;
    } flag_mask_t;

    function automatic flag_mask_t mask_for(input logic [OP_W-1:0] op);
        flag_mask_t m;
        m = '0;
        case (op)
            OP_ADD, OP_SUB: begin
                m.upd_nz = 1'b1;
                m.upd_vc = 1'b1;
            end
            OP_LDW, OP_LDB, OP_AND, OP_OR, OP_INV, OP_NEG: m.upd_nz = 1'b1;
            default: m = '0;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/word_alu_adder.sv
module word_alu_adder #(
    parameter int unsigned W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W-1:0] sum,
    output logic         carry,
    output logic         ovf
);
    logic [W-1:0] b_eff;
    logic [W:0]   full;

    always_comb begin
        b_eff = sub ? ~b : b;
        full  = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, sub};
        sum   = full[W-1:0];
        carry = full[W];
        ovf   = (a[W-1] == b_eff[W-1]) && (full[W-1] != a[W-1]);
    end
endmodule

// File: rtl/word_alu_logic.sv
module word_alu_logic #(
    parameter int unsigned W  = 16,
    parameter int unsigned BW = 8
) (
    input  word_alu_pkg::alu_op_e op,
    input  logic [W-1:0]          a,
    input  logic [W-1:0]          b,
    output logic [W-1:0]          y
);
    import word_alu_pkg::*;

    localparam int unsigned HI_W = W - BW;

    logic [W-1:0] byte_merge;

    generate
        if (HI_W > 0) begin : g_hi
            assign byte_merge = {a[W-1:BW], b[BW-1:0]};
        end else begin : g_nohi
            assign byte_merge = b;
        end
    endgenerate

    always_comb begin
        case (op)
            OP_LDW:  y = b;
            OP_LDB:  y = byte_merge;
            OP_AND:  y = a & b;
            OP_OR:   y = a | b;
            OP_INV:  y = ~a;
            OP_NEG:  y = (~a) + {{(W-1){1'b0}}, 1'b1};
            default: y = a;
        endcase
    end
endmodule

// File: rtl/word_alu_nzvc.sv
module word_alu_nzvc
    import word_alu_pkg::*;
#(
    parameter int unsigned W  = WORD_W,
    parameter int unsigned BW = BYTE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [W-1:0]  reg_opnd,
    input  logic [W-1:0]  mem_opnd,
    input  logic [3:0]    op_sel,
    input  logic          flag_we,
    output logic [W-1:0]  result,
    output logic          flag_n,
    output logic          flag_z,
    output logic          flag_v,
    output logic          flag_c
);
    typedef struct packed {
        nzvc_t flags;
    } state_t;

    state_t     state_d, state_q;
    alu_op_e    op;
    logic       is_arith;
    logic [W-1:0] arith_sum, logic_y;
    logic       arith_c, arith_v;
    flag_mask_t mask;

    assign op       = alu_op_e'(op_sel);
    assign is_arith = (op == OP_ADD) || (op == OP_SUB);

    word_alu_adder #(.W(W)) u_adder (
        .a     (reg_opnd),
        .b     (mem_opnd),
        .sub   (op == OP_SUB),
        .sum   (arith_sum),
        .carry (arith_c),
        .ovf   (arith_v)
    );

    word_alu_logic #(.W(W), .BW(BW)) u_logic (
        .op (op),
        .a  (reg_opnd),
        .b  (mem_opnd),
        .y  (logic_y)
    );

    always_comb begin
        result  = is_arith ? arith_sum : logic_y;
        mask    = mask_for(op_sel);
        state_d = state_q;
        if (flag_we) begin
            if (mask.upd_nz) begin
                state_d.flags.n = result[W-1];
                state_d.flags.z = (result == '0);
            end
            if (mask.upd_vc) begin
                state_d.flags.v = arith_v;
                state_d.flags.c = arith_c;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= '0;
        else     state_q <= state_d;
    end

    assign flag_n = state_q.flags.n;
    assign flag_z = state_q.flags.z;
    assign flag_v = state_q.flags.v;
    assign flag_c = state_q.flags.c;
endmodule

// File: rtl/word_alu_nzvc_chk.sv
module word_alu_nzvc_chk (
    input logic        clk,
    input logic        rst,
    input logic [15:0] reg_opnd,
    input logic [15:0] mem_opnd,
    input logic [3:0]  op_sel,
    input logic        flag_we,
    input logic [15:0] result,
    input logic        flag_n,
    input logic        flag_z,
    input logic        flag_v,
    input logic        flag_c
);
    logic [3:0]  flags;
    logic [16:0] add_full;
    logic        nz_op, vc_op;

    assign flags    = {flag_n, flag_z, flag_v, flag_c};
    assign add_full = {1'b0, reg_opnd} + {1'b0, mem_opnd};
    assign vc_op    = (op_sel == 4'd3) || (op_sel == 4'd4);
    assign nz_op    = vc_op || (op_sel inside {4'd1, 4'd2, 4'd5, 4'd6, 4'd7, 4'd8});

    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> flags == 4'b0000);

    assert_add_carry_R2: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(flag_we) && $past(op_sel) == 4'd3) |-> flag_c == $past(add_full[16]));

    assert_logic_keeps_vc_R4: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(nz_op) && !$past(vc_op)) |-> ($stable(flag_v) && $stable(flag_c)));

    assert_ldb_high_byte_R7: assert property (@(posedge clk) disable iff (rst)
        (op_sel == 4'd2) |-> result[15:8] == reg_opnd[15:8]);

    assert_pass_unchanged_R8: assert property (@(posedge clk) disable iff (rst)
        (!nz_op) |-> result == reg_opnd);

    assert_no_write_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && (!$past(flag_we) || !$past(nz_op))) |-> $stable(flags));

    assert_zero_flag_R10: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(flag_we) && $past(nz_op)) |-> (flag_z == ($past(result) == 16'h0000)));
endmodule

bind word_alu_nzvc word_alu_nzvc_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .reg_opnd (reg_opnd),
    .mem_opnd (mem_opnd),
    .op_sel   (op_sel),
    .flag_we  (flag_we),
    .result   (result),
    .flag_n   (flag_n),
    .flag_z   (flag_z),
    .flag_v   (flag_v),
    .flag_c   (flag_c)
);

// File: tb/word_alu_nzvc_bench.sv
module word_alu_nzvc_bench;

    typedef struct packed {
        logic [3:0]  op;
        logic [15:0] a;
        logic [15:0] b;
        logic        we;
        logic [15:0] res;
        logic [3:0]  nzvc;
    } vec_t;

    localparam int NV = 19;
    // Flags listed as {N,Z,V,C} after the edge; each row follows the previous.
    localparam vec_t TABLE [NV] = '{
        '{4'd3, 16'hFFF9, 16'h0005, 1'b1, 16'hFFFE, 4'b1000}, // R2
        '{4'd3, 16'h7FFF, 16'h0001, 1'b1, 16'h8000, 4'b1010}, // R2 overflow
        '{4'd5, 16'h5DC3, 16'h00FF, 1'b1, 16'h00C3, 4'b0010}, // R4
        '{4'd3, 16'hFFFF, 16'h0001, 1'b1, 16'h0000, 4'b0101}, // R2 carry, zero
        '{4'd6, 16'h5DC3, 16'h00FF, 1'b1, 16'h5DFF, 4'b0001}, // R4
        '{4'd4, 16'h0003, 16'h0009, 1'b1, 16'hFFFA, 4'b1000}, // R3 borrow
        '{4'd4, 16'h0009, 16'h0003, 1'b1, 16'h0006, 4'b0001}, // R3
        '{4'd4, 16'h8000, 16'h0001, 1'b1, 16'h7FFF, 4'b0011}, // R3 overflow
        '{4'd7, 16'h0003, 16'h1111, 1'b1, 16'hFFFC, 4'b1011}, // R5 invert
        '{4'd8, 16'h0003, 16'h2222, 1'b1, 16'hFFFD, 4'b1011}, // R5 negate
        '{4'd2, 16'h036D, 16'hAB92, 1'b1, 16'h0392, 4'b0011}, // R7
        '{4'd1, 16'h5555, 16'h0000, 1'b1, 16'h0000, 4'b0111}, // R6
        '{4'd0, 16'h1234, 16'h0000, 1'b1, 16'h1234, 4'b0111}, // R8 pass
        '{4'd3, 16'h0001, 16'h0001, 1'b0, 16'h0002, 4'b0111}, // R9
        '{4'd4, 16'h0005, 16'h0005, 1'b1, 16'h0000, 4'b0101}, // R3 equal
        '{4'd8, 16'h0000, 16'hFFFF, 1'b1, 16'h0000, 4'b0101}, // R5 neg zero
        '{4'd2, 16'h80FF, 16'h7F00, 1'b1, 16'h8000, 4'b1001}, // R7 N from high byte
        '{4'd15, 16'h4321, 16'h0000, 1'b1, 16'h4321, 4'b1001}, // R8 unused code
        '{4'd3, 16'h8000, 16'h8000, 1'b1, 16'h0000, 4'b0111}  // R2 V and C
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] reg_opnd = '0;
    logic [15:0] mem_opnd = '0;
    logic [3:0]  op_sel = '0;
    logic        flag_we = 1'b0;
    logic [15:0] result;
    logic        flag_n, flag_z, flag_v, flag_c;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    word_alu_nzvc u_word_alu_nzvc (
        .clk      (clk),
        .rst      (rst),
        .reg_opnd (reg_opnd),
        .mem_opnd (mem_opnd),
        .op_sel   (op_sel),
        .flag_we  (flag_we),
        .result   (result),
        .flag_n   (flag_n),
        .flag_z   (flag_z),
        .flag_v   (flag_v),
        .flag_c   (flag_c)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] flags4();
        return {12'h000, flag_n, flag_z, flag_v, flag_c};
    endfunction

    initial begin
        #1_000_000;
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [3:0] prev;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        #1 check("R1 reset state", flags4(), 16'h0000);
        prev = 4'b0000;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            op_sel   = TABLE[i].op;
            reg_opnd = TABLE[i].a;
            mem_opnd = TABLE[i].b;
            flag_we  = TABLE[i].we;
            #1;
            check($sformatf("R2-R8 result row %0d", i), result, TABLE[i].res);
            check($sformatf("R10 flags before edge row %0d", i), flags4(), {12'h000, prev});
            @(negedge clk);
            #1 check($sformatf("R9 R10 flags after edge row %0d", i), flags4(), {12'h000, TABLE[i].nzvc});
            prev = TABLE[i].nzvc;
        end

        // R1: reset wins over a flag write in the same cycle
        @(negedge clk);
        op_sel = 4'd3; reg_opnd = 16'h8000; mem_opnd = 16'h8000; flag_we = 1'b1; rst = 1'b1;
        @(negedge clk);
        rst = 1'b0; flag_we = 1'b0;
        #1 check("R1 reset over write", flags4(), 16'h0000);

        // R9: write disabled across several operations leaves flags clear
        for (int k = 3; k <= 8; k++) begin
            @(negedge clk);
            op_sel = 4'(k); reg_opnd = 16'hFFFF; mem_opnd = 16'h0001; flag_we = 1'b0;
        end
        @(negedge clk);
        #1 check("R9 no write holds", flags4(), 16'h0000);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule